// File: doc/BRIEF.md
# GPIO Port Configuration Register Bank

This block holds the configuration and output state of one port of up to 32 general-purpose pins. It sits behind a simple word-addressed register interface. Software never needs a read-modify-write. Each configuration group has three views. One is readable and shows the stored bits. The second ORs the written word into the stored bits. The third removes every bit written as one. This lets independent drivers change their own pins without racing one another.

The stored bits decide the role of each pin. With both the peripheral-function bit and the select bit low, the pin is plain I/O and its direction bit enables the output driver. With the function bit high, the pin is handed to a peripheral and the select bit picks one of two alternate devices. With the function bit low and the select bit high, the pin is an interrupt source. The direction and trigger bits are then exported to a separate interrupt detector, which reports events back through a per-pin flag input.

The pad inputs pass through a two-stage synchronizer. The level view shows the synchronized pads, not the stored output data.

Top module: `gpio_port_bank`

## Requirements
- R1: Group g sits at byte offset 0x10*g, with level=0, data=1, mask=2, pull-disable=3, function=4, select=5, direction=6, trigger=7, flag=8. A read of offset 0x10*g returns that group's current value in the same cycle.
- R2: For groups 1 to 7, a write to offset 0x10*g+0x4 sets every bit written as 1 and leaves all other bits unchanged. The new value is visible after the next rising edge.
- R3: For groups 1 to 7, a write to offset 0x10*g+0x8 clears every bit written as 1. A write to 0x84 clears the flag bits written as 1. All other bits stay unchanged.
- R4: After reset, the data, pull-disable, function, select, direction, trigger and flag groups are all zero, and the mask group is all ones.
- R5: The level group returns padIn delayed by two rising edges. A new pad value is not yet visible after one edge and is visible after the second. Writes to the data group do not change it.
- R6: padOut equals the data group. padOutEn of a pin is 1 exactly when its direction bit is 1 and its function and select bits are both 0.
- R7: padAltEn equals the function group and padAltSel equals the select group.
- R8: padPullEn of a pin is the inverse of its pull-disable bit, so pull-disable=0 enables the pull-up.
- R9: irqMask, irqFun, irqSel, irqDir and irqTrig equal the mask, function, select, direction and trigger groups. irqFlag equals the flag group.
- R10: A 1 on irqFlagIn sets that flag bit at the next rising edge. When a set and a clear of the same flag bit occur in the same cycle, the set wins.
- R11: Writes are ignored at the following offsets: any base offset (0x10*g), the level group, offset 0x88, offset +0xC of any group, offsets above 0x8F, and addresses with either of the two low bits set. Reads of any offset other than a base offset return zero, and rdData is zero whenever rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read enable for combinational read |
| addr | input | ADDR_W | Byte offset |
| wrData | input | PIN_CNT | Write word, used as a bit mask by set and clear views |
| rdData | output | PIN_CNT | Read word |
| padIn | input | PIN_CNT | Asynchronous pad input levels |
| padOut | output | PIN_CNT | Output value per pin |
| padOutEn | output | PIN_CNT | Output driver enable per pin |
| padPullEn | output | PIN_CNT | Pull-up enable per pin |
| padAltEn | output | PIN_CNT | Pin handed to a peripheral |
| padAltSel | output | PIN_CNT | Alternate device choice for the pad mux |
| irqFlagIn | input | PIN_CNT | Event pulses from the interrupt detector |
| irqMask | output | PIN_CNT | Mask bits to the interrupt detector |
| irqFun | output | PIN_CNT | Function bits to the interrupt detector |
| irqSel | output | PIN_CNT | Select bits to the interrupt detector |
| irqDir | output | PIN_CNT | Direction/polarity bits to the interrupt detector |
| irqTrig | output | PIN_CNT | Trigger bits to the interrupt detector |
| irqFlag | output | PIN_CNT | Stored event flags |

## Verification
The assertions assume that wrEn and rdEn are synchronous to clk and that a write word is held stable while wrEn is high. They also assume that irqFlagIn is a clean synchronous pulse. Only padIn may change freely. The synchronizer check holds only once two edges have passed since reset. The stimulus respects these limits by driving every bus input and irqFlagIn on the falling edge. It changes padIn only on the falling edge as well, so the two-edge latency is counted exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GRP_CNT     = 9;
  localparam int CFG_LO      = 1;
  localparam int CFG_HI      = 7;
  localparam int SYNC_STAGES = 2;

  localparam int GRP_LEVEL = 0;
  localparam int GRP_DATA  = 1;
  localparam int GRP_MASK  = 2;
  localparam int GRP_PULL  = 3;
  localparam int GRP_FUNC  = 4;
  localparam int GRP_SEL   = 5;
  localparam int GRP_DIR   = 6;
  localparam int GRP_TRIG  = 7;
  localparam int GRP_FLAG  = 8;

  // view within a group, from addr[3:2]
  typedef enum logic [1:0] {
    VIEW_READ = 2'd0,
    VIEW_SET  = 2'd1,
    VIEW_CLR  = 2'd2,
    VIEW_NONE = 2'd3
  } view_e;

  typedef struct packed {
    logic [GRP_CNT-1:0] setEn;
    logic [GRP_CNT-1:0] clrEn;
    logic               rdHit;
    logic [3:0]         rdGrp;
  } strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);
  logic [3:0] grpIdx;
  view_e      view;
  logic       addrOk;

  assign grpIdx = addr[7:4];
  assign view   = view_e'(addr[3:2]);
  assign addrOk = (addr[1:0] == 2'b00) && ((addr >> 8) == '0) && (int'(grpIdx) < GRP_CNT);

  always_comb begin
    strb = '0;
    if (wrEn && addrOk) begin
      for (int g = 0; g < GRP_CNT; g++) begin
        if (grpIdx == 4'(g)) begin
          if (g == GRP_FLAG) begin
            strb.clrEn[g] = (view == VIEW_SET);
          end else if (g != GRP_LEVEL) begin
            strb.setEn[g] = (view == VIEW_SET);
            strb.clrEn[g] = (view == VIEW_CLR);
          end
        end
      end
    end
    if (rdEn && addrOk && view == VIEW_READ) begin
      strb.rdHit = 1'b1;
      strb.rdGrp = grpIdx;
    end
  end

  // R11: at most one group/view updated per write
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setEn, strb.clrEn}));

  // R11: a write to a readable view or a misaligned address touches nothing
  p_ro_view_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr[3:2] == 2'b00 || addr[1:0] != 2'b00)) |-> (strb.setEn == '0 && strb.clrEn == '0));

  // R11: no read hit without rdEn
  p_rd_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !strb.rdHit);
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [STAGES-1:0][W-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= dIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_CNT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [PIN_CNT-1:0] wrMask,
  input  logic [PIN_CNT-1:0] padIn,
  input  logic [PIN_CNT-1:0] irqFlagIn,
  output logic [PIN_CNT-1:0] rdData,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOutEn,
  output logic [PIN_CNT-1:0] padPullEn,
  output logic [PIN_CNT-1:0] padAltEn,
  output logic [PIN_CNT-1:0] padAltSel,
  output logic [PIN_CNT-1:0] irqMask,
  output logic [PIN_CNT-1:0] irqFun,
  output logic [PIN_CNT-1:0] irqSel,
  output logic [PIN_CNT-1:0] irqDir,
  output logic [PIN_CNT-1:0] irqTrig,
  output logic [PIN_CNT-1:0] irqFlag
);
  logic [CFG_HI:CFG_LO][PIN_CNT-1:0] cfgQ;
  logic [PIN_CNT-1:0] flagQ;
  logic [PIN_CNT-1:0] levelSync;
  logic [1:0]         warmQ;

  gpio_bank_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .dIn(padIn), .dOut(levelSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = CFG_LO; g <= CFG_HI; g++) cfgQ[g] <= (g == GRP_MASK) ? '1 : '0;
    end else begin
      for (int g = CFG_LO; g <= CFG_HI; g++) begin
        if (strb.setEn[g])      cfgQ[g] <= cfgQ[g] | wrMask;
        else if (strb.clrEn[g]) cfgQ[g] <= cfgQ[g] & ~wrMask;
      end
    end
  end

  // a fresh event outranks a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~(strb.clrEn[GRP_FLAG] ? wrMask : '0)) | irqFlagIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmQ <= '0;
    else if (warmQ != 2'd3)  warmQ <= warmQ + 2'd1;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdHit) begin
      if (strb.rdGrp == 4'(GRP_LEVEL)) rdData = levelSync;
      if (strb.rdGrp == 4'(GRP_FLAG))  rdData = flagQ;
      for (int g = CFG_LO; g <= CFG_HI; g++)
        if (strb.rdGrp == 4'(g)) rdData = cfgQ[g];
    end
  end

  assign padOut    = cfgQ[GRP_DATA];
  assign padOutEn  = cfgQ[GRP_DIR] & ~cfgQ[GRP_FUNC] & ~cfgQ[GRP_SEL];
  assign padPullEn = ~cfgQ[GRP_PULL];
  assign padAltEn  = cfgQ[GRP_FUNC];
  assign padAltSel = cfgQ[GRP_SEL];
  assign irqMask   = cfgQ[GRP_MASK];
  assign irqFun    = cfgQ[GRP_FUNC];
  assign irqSel    = cfgQ[GRP_SEL];
  assign irqDir    = cfgQ[GRP_DIR];
  assign irqTrig   = cfgQ[GRP_TRIG];
  assign irqFlag   = flagQ;

  // R2: set view raises the written bits and keeps the rest
  p_set_raise_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn[GRP_DATA] |=> ((padOut & $past(wrMask)) == $past(wrMask)));
  p_set_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn[GRP_DATA] |=> ((padOut & ~$past(wrMask)) == ($past(padOut) & ~$past(wrMask))));

  // R3: clear view drops the written bits
  p_clr_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn[GRP_DIR] |=> ((irqDir & $past(wrMask)) == '0));

  // R11: without a strobe the group holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setEn[GRP_DIR] && !strb.clrEn[GRP_DIR]) |=> $stable(irqDir));

  // R11: read-only groups never receive write strobes
  p_no_ro_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setEn[GRP_LEVEL] || strb.clrEn[GRP_LEVEL] || strb.setEn[GRP_FLAG]));

  // R10: an incoming event is always recorded
  p_flag_win_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlagIn != '0) |=> ((irqFlag & $past(irqFlagIn)) == $past(irqFlagIn)));

  // R5: level view lags the pads by two edges
  p_sync_lag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (warmQ >= 2'd2) |-> (levelSync == $past(padIn, 2)));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_CNT = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PIN_CNT-1:0] wrData,
  output logic [PIN_CNT-1:0] rdData,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOutEn,
  output logic [PIN_CNT-1:0] padPullEn,
  output logic [PIN_CNT-1:0] padAltEn,
  output logic [PIN_CNT-1:0] padAltSel,
  input  logic [PIN_CNT-1:0] irqFlagIn,
  output logic [PIN_CNT-1:0] irqMask,
  output logic [PIN_CNT-1:0] irqFun,
  output logic [PIN_CNT-1:0] irqSel,
  output logic [PIN_CNT-1:0] irqDir,
  output logic [PIN_CNT-1:0] irqTrig,
  output logic [PIN_CNT-1:0] irqFlag
);
  strobe_t strb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  gpio_bank_dp #(.PIN_CNT(PIN_CNT)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrMask(wrData), .padIn(padIn),
    .irqFlagIn(irqFlagIn), .rdData(rdData), .padOut(padOut), .padOutEn(padOutEn),
    .padPullEn(padPullEn), .padAltEn(padAltEn), .padAltSel(padAltSel),
    .irqMask(irqMask), .irqFun(irqFun), .irqSel(irqSel), .irqDir(irqDir),
    .irqTrig(irqTrig), .irqFlag(irqFlag)
  );
endmodule

// File: tb/tb_gpio_port_bank.sv
`timescale 1ns/1ps
module tb_gpio_port_bank;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0, padIn = '0, irqFlagIn = '0;
  logic [31:0] rdData, padOut, padOutEn, padPullEn, padAltEn, padAltSel;
  logic [31:0] irqMask, irqFun, irqSel, irqDir, irqTrig, irqFlag;

  int checks = 0, errors = 0;
  logic [31:0] model [0:8];
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOutEn(padOutEn),
    .padPullEn(padPullEn), .padAltEn(padAltEn), .padAltSel(padAltSel),
    .irqFlagIn(irqFlagIn), .irqMask(irqMask), .irqFun(irqFun), .irqSel(irqSel),
    .irqDir(irqDir), .irqTrig(irqTrig), .irqFlag(irqFlag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); rdEn = 1'b1; addr = a; #1;
    chk(req, rdData, exp);
    rdEn = 1'b0;
  endtask

  task automatic outChk();
    #1;
    chk("R6 padOut", padOut, model[1]);
    chk("R6 padOutEn", padOutEn, model[6] & ~model[4] & ~model[5]);
    chk("R7 padAltEn", padAltEn, model[4]);
    chk("R7 padAltSel", padAltSel, model[5]);
    chk("R8 padPullEn", padPullEn, ~model[3]);
    chk("R9 irqMask", irqMask, model[2]);
    chk("R9 irqFun", irqFun, model[4]);
    chk("R9 irqSel", irqSel, model[5]);
    chk("R9 irqDir", irqDir, model[6]);
    chk("R9 irqTrig", irqTrig, model[7]);
    chk("R9 irqFlag", irqFlag, model[8]);
  endtask

  task automatic allChk(string req);
    for (int g = 1; g <= 8; g++) rdChk(req, 8'(g * 16), model[g]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g <= 8; g++) model[g] = '0;
    model[2] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 reset values, R1 base offsets
    allChk("R4 reset");
    rdChk("R1 level base", 8'h00, 32'h0);
    outChk();

    // R1 R2 R3: sweep every configuration group with computed patterns
    for (int g = 1; g <= 7; g++) begin
      for (int i = 0; i < 6; i++) begin
        logic [31:0] p, q;
        p = (32'h9E37_79B9 * (g * 7 + i + 1)) ^ (32'h1 << (i * 5));
        q = {p[15:0], p[31:16]} ^ 32'h3333_CCCC;
        wr(8'(g * 16 + 4), p);
        model[g] = model[g] | p;
        outChk();
        rdChk("R2 set view", 8'(g * 16), model[g]);
        wr(8'(g * 16 + 8), q);
        model[g] = model[g] & ~q;
        outChk();
        rdChk("R3 clear view", 8'(g * 16), model[g]);
      end
    end

    // R6: pin role sweep over all eight function/select/direction combinations
    for (int c = 0; c < 8; c++) begin
      wr(8'h48, '1); wr(8'h58, '1); wr(8'h68, '1);
      model[4] = '0; model[5] = '0; model[6] = '0;
      if (c[2]) begin wr(8'h44, 32'h0F0F_0F0F); model[4] = 32'h0F0F_0F0F; end
      if (c[1]) begin wr(8'h54, 32'h00FF_00FF); model[5] = 32'h00FF_00FF; end
      if (c[0]) begin wr(8'h64, 32'h3C3C_C3C3); model[6] = 32'h3C3C_C3C3; end
      outChk();
    end

    // R11: ignored writes and zero reads
    wr(8'h00, '1); wr(8'h04, '1); wr(8'h08, '1); wr(8'h20, '0);
    wr(8'h6C, '1); wr(8'h88, '1); wr(8'h90, '1); wr(8'h94, '1);
    wr(8'h65, '1); wr(8'h1A, '1); wr(8'hF4, '1);
    allChk("R11 ignored writes");
    outChk();
    rdChk("R11 set view reads zero", 8'h64, 32'h0);
    rdChk("R11 clear view reads zero", 8'h28, 32'h0);
    rdChk("R11 undefined reads zero", 8'hA0, 32'h0);
    @(negedge clk); rdEn = 1'b0; addr = 8'h20; #1;
    chk("R11 rdEn low", rdData, 32'h0);

    // R5: two-edge synchronizer latency, independent of data group
    wr(8'h14, 32'hFFFF_0000); model[1] = model[1] | 32'hFFFF_0000;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] prev, nv;
      prev = padIn;
      nv = 32'hC0FF_EE00 ^ (32'h0101_0101 << i) ^ (32'h1 * i * 977);
      @(negedge clk); padIn = nv;
      @(negedge clk); rdEn = 1'b1; addr = 8'h00; #1;
      chk("R5 one edge old", rdData, prev);
      @(negedge clk); #1;
      chk("R5 two edges new", rdData, nv);
      rdEn = 1'b0;
    end

    // R10: flag set, clear, and same-cycle set-wins
    @(negedge clk); irqFlagIn = 32'h8000_0011;
    @(negedge clk); irqFlagIn = '0;
    model[8] = 32'h8000_0011;
    rdChk("R10 flag set", 8'h80, model[8]);
    wr(8'h84, 32'h0000_0010); model[8] = 32'h8000_0001;
    rdChk("R3 flag clear", 8'h80, model[8]);
    @(negedge clk); irqFlagIn = 32'h0000_0001; wrEn = 1'b1; addr = 8'h84; wrData = 32'h8000_0001;
    @(negedge clk); irqFlagIn = '0; wrEn = 1'b0;
    model[8] = 32'h0000_0001;
    rdChk("R10 set wins over clear", 8'h80, model[8]);
    outChk();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule